// File: doc/BRIEF.md
# I2C Address-Match and Direction Tracker

This block follows an already synchronized I2C bus and keeps two status flags for one bus controller. The bus arrives as one-cycle event strobes: start detected, stop detected, SCL rising and SCL falling. It also receives the sampled SDA level. After every start, the block counts SCL rising edges through the first byte. It compares the seven address bits, received MSB first, against a local slave address. It then captures the eighth bit, the read/write direction bit. The first flag, `addrMatch`, reports that the first byte carried the local address.

The second flag, `txFlag`, reports that the controller is in transmit status. It comes from the direction bit. In controller (master) mode that bit is the value the controller is itself driving. In target (slave) mode it is the value received on SDA. The flag gates the SDA output driver, and the driver turns on only from the falling SCL edge that ends the ninth clock of the first byte.

Software-style strobes can drop out of communication at any time: release, disable (enable falling), and cancel of the ninth-clock wait. An arbitration-lost pulse does the same for the direction flag. Each of these sends SDA back to high impedance. The bit counter stops once the first byte is over, so later data bytes never retrigger the compare.

Top module: `i2c_addr_dir_tracker`

## Requirements
- R1: After reset, `addrMatch`, `txFlag` and `sdaOe` are 0.
- R2: On the eighth SCL rise after a start, `addrMatch` becomes 1 in the following cycle if the seven bits sampled on rises one to seven (MSB first) equal `localAddr`. Otherwise it stays 0.
- R3: `addrMatch` is cleared by a start, a stop, a release strobe, or a 1-to-0 change of `enable`.
- R4: In target mode (`isMaster`=0), `txFlag` takes the value of `sdaIn` at the eighth SCL rise after a start (1 = transmit).
- R5: In controller mode (`isMaster`=1), `txFlag` takes the value of `txBit` at the eighth SCL rise, and `sdaIn` is ignored for this.
- R6: `txFlag` is cleared by a start, a stop, a release strobe, a 1-to-0 change of `enable`, or `arbLost`. `arbLost` leaves `addrMatch` unchanged.
- R7: `waitCancel` clears `txFlag` (and so `sdaOe`) only after the ninth SCL rise of the first byte. Before that rise it has no effect.
- R8: `sdaOe` is 1 only while `txFlag` is 1 and the SCL fall that follows the ninth rise of the first byte has occurred. It is 0 between the eighth rise and that fall.
- R9: After nine SCL rises, further rises and falls until the next start leave `addrMatch` and `txFlag` unchanged.
- R10: When a clear event (release, stop, disable) falls in the same cycle as the eighth SCL rise, both flags end at 0.
- R11: While `enable` is 0, bus activity sets neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; a 1-to-0 change drops out of communication |
| isMaster | input | 1 | 1 = controller mode, 0 = target mode |
| startDet | input | 1 | One-cycle pulse: start condition seen |
| stopDet | input | 1 | One-cycle pulse: stop condition seen |
| sclRise | input | 1 | One-cycle pulse: SCL rising edge |
| sclFall | input | 1 | One-cycle pulse: SCL falling edge |
| sdaIn | input | 1 | Synchronized SDA level |
| txBit | input | 1 | Bit the controller is driving (used as direction bit in controller mode) |
| localAddr | input | 7 | Local slave address |
| relStrobe | input | 1 | Release-communication strobe |
| waitCancel | input | 1 | Wait-cancel strobe |
| arbLost | input | 1 | Arbitration-lost pulse |
| addrMatch | output | 1 | First byte matched the local address |
| txFlag | output | 1 | 1 = transmit status, 0 = receive status |
| sdaOe | output | 1 | SDA output driver enable (0 = high impedance) |

## Verification
The hardest points to reach are the narrow windows around the end of the first byte. These are the gap between the eighth rise and the ninth fall, where `txFlag` is already 1 but `sdaOe` must still be 0, and the cycle in which a clear strobe lands on the eighth rise itself. The stimulus drives SCL edges one bit at a time, so it can stop inside these windows. It pulses `waitCancel` once before and once after the ninth rise, and raises `relStrobe` in the very cycle of the eighth rise.

// File: rtl/adt_pkg.sv
package adt_pkg;

  // Commands from control to datapath
  typedef struct packed {
    logic restart;  // new frame: reset bit count
    logic abort;    // leave communication: park the counter
  } adt_cmd_t;

  // Byte-progress strobes from datapath to control
  typedef struct packed {
    logic lsbEdge;  // eighth SCL rise of the first byte
    logic addrEq;   // collected address equals local address
    logic dirBit;   // direction bit value for the current mode
    logic atNinth;  // ninth rise of the first byte has passed
    logic armed;    // ninth fall has passed, driver may turn on
  } adt_stat_t;

endpackage

// File: rtl/adt_datapath.sv
module adt_datapath
  import adt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  adt_cmd_t          cmd,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaIn,
  input  logic              txBit,
  input  logic              isMaster,
  input  logic [ADDR_W-1:0] localAddr,
  output adt_stat_t         stat
);

  localparam int LSB_IDX = ADDR_W;      // rises seen before the direction bit
  localparam int ACK_IDX = ADDR_W + 2;  // rises in the whole first byte incl. ack
  localparam int CNT_W   = $clog2(ACK_IDX + 1);
  localparam logic [CNT_W-1:0] CNT_LSB  = CNT_W'(LSB_IDX);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ACK_IDX);

  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] addrShift;
  logic              inFrame;
  logic              armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= CNT_DONE;
      inFrame <= 1'b0;
      armed   <= 1'b0;
    end else if (cmd.abort) begin
      bitCnt  <= CNT_DONE;
      inFrame <= 1'b0;
      armed   <= 1'b0;
    end else if (cmd.restart) begin
      bitCnt  <= '0;
      inFrame <= 1'b1;
      armed   <= 1'b0;
    end else begin
      if (sclRise && bitCnt < CNT_DONE) bitCnt <= bitCnt + 1'b1;
      if (inFrame && sclFall && bitCnt == CNT_DONE) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrShift <= '0;
    end else if (sclRise && bitCnt < CNT_LSB) begin
      addrShift <= {addrShift[ADDR_W-2:0], sdaIn};
    end
  end

  always_comb begin
    stat.lsbEdge = sclRise && bitCnt == CNT_LSB && inFrame && !cmd.abort && !cmd.restart;
    stat.addrEq  = (addrShift == localAddr);
    stat.dirBit  = isMaster ? txBit : sdaIn;
    stat.atNinth = inFrame && bitCnt == CNT_DONE;
    stat.armed   = armed;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_DONE);  // R9
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.restart && !cmd.abort) |=> bitCnt == '0);  // R2
  AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(sclFall));  // R8

endmodule

// File: rtl/adt_control.sv
module adt_control
  import adt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sclRise,
  input  logic      relStrobe,
  input  logic      waitCancel,
  input  logic      arbLost,
  input  adt_stat_t stat,
  output adt_cmd_t  cmd,
  output logic      addrMatch,
  output logic      txFlag,
  output logic      sdaOe
);

  logic enablePrev;
  logic enableFall;
  logic clrMatch;
  logic clrTx;

  always_ff @(posedge clk) begin
    if (!rstN) enablePrev <= 1'b0;
    else       enablePrev <= enable;
  end

  always_comb begin
    enableFall  = enablePrev && !enable;
    cmd.abort   = !enable || stopDet || relStrobe;
    cmd.restart = startDet;
    clrMatch    = startDet || stopDet || relStrobe || enableFall;
    clrTx       = clrMatch || arbLost || (waitCancel && stat.atNinth);
  end

  // Clear events take priority over the eighth-rise set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      txFlag    <= 1'b0;
    end else begin
      if (clrMatch)                         addrMatch <= 1'b0;
      else if (stat.lsbEdge && stat.addrEq) addrMatch <= 1'b1;

      if (clrTx)             txFlag <= 1'b0;
      else if (stat.lsbEdge) txFlag <= stat.dirBit;
    end
  end

  assign sdaOe = txFlag && stat.armed;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!addrMatch && !txFlag));  // R3
  AST_ARB_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |=> !txFlag);  // R6
  AST_MATCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrMatch) |-> $past(sclRise));  // R2
  AST_DISABLE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |=> !sdaOe);  // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!addrMatch && !txFlag));  // R11

endmodule

// File: rtl/i2c_addr_dir_tracker.sv
module i2c_addr_dir_tracker
  import adt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              isMaster,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaIn,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              relStrobe,
  input  logic              waitCancel,
  input  logic              arbLost,
  output logic              addrMatch,
  output logic              txFlag,
  output logic              sdaOe
);

  adt_cmd_t  cmd;
  adt_stat_t stat;

  adt_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclRise(sclRise), .sclFall(sclFall),
    .sdaIn(sdaIn), .txBit(txBit), .isMaster(isMaster), .localAddr(localAddr),
    .stat(stat)
  );

  adt_control u_control (
    .clk(clk), .rstN(rstN), .enable(enable), .startDet(startDet),
    .stopDet(stopDet), .sclRise(sclRise), .relStrobe(relStrobe),
    .waitCancel(waitCancel), .arbLost(arbLost), .stat(stat), .cmd(cmd),
    .addrMatch(addrMatch), .txFlag(txFlag), .sdaOe(sdaOe)
  );

endmodule

// File: tb/i2c_addr_dir_tracker_bench.sv
module i2c_addr_dir_tracker_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, isMaster = 1'b0, startDet = 1'b0, stopDet = 1'b0;
  logic sclRise = 1'b0, sclFall = 1'b0, sdaIn = 1'b1, txBit = 1'b0;
  logic [6:0] localAddr = '0;
  logic relStrobe = 1'b0, waitCancel = 1'b0, arbLost = 1'b0;
  logic addrMatch, txFlag, sdaOe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_addr_dir_tracker u_i2c_addr_dir_tracker (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .startDet(startDet), .stopDet(stopDet), .sclRise(sclRise), .sclFall(sclFall),
    .sdaIn(sdaIn), .txBit(txBit), .localAddr(localAddr), .relStrobe(relStrobe),
    .waitCancel(waitCancel), .arbLost(arbLost), .addrMatch(addrMatch),
    .txFlag(txFlag), .sdaOe(sdaOe)
  );

  // {isMaster, localAddr[6:0], frame[7:0]}, frame = {addr, dir}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 7'h50, 7'h50, 1'b1},
    {1'b0, 7'h50, 7'h51, 1'b0},
    {1'b0, 7'h2A, 7'h2A, 1'b0},
    {1'b1, 7'h13, 7'h13, 1'b1},
    {1'b1, 7'h7F, 7'h7E, 1'b1},
    {1'b0, 7'h00, 7'h00, 1'b1},
    {1'b1, 7'h41, 7'h41, 1'b0},
    {1'b0, 7'h7F, 7'h7F, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    startDet = 1'b1; @(negedge clk); startDet = 1'b0; @(negedge clk);
  endtask

  task automatic pulseStop();
    stopDet = 1'b1; @(negedge clk); stopDet = 1'b0; @(negedge clk);
  endtask

  // One SCL clock: rise cycle then fall cycle
  task automatic sendBit(input logic b);
    sdaIn = b; sclRise = 1'b1; @(negedge clk);
    sclRise = 1'b0; sclFall = 1'b1; @(negedge clk);
    sclFall = 1'b0;
  endtask

  // Eight bits of the first byte; in controller mode the LSB on SDA is the
  // inverse of the direction bit so only txBit can give the right answer
  task automatic sendFirst(input logic [7:0] frame, input logic master);
    for (int i = 7; i >= 1; i--) sendBit(frame[i]);
    txBit = master ? frame[0] : ~frame[0];
    sendBit(master ? ~frame[0] : frame[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addrMatch", addrMatch, 1'b0);
    chk("R1 txFlag", txFlag, 1'b0);
    chk("R1 sdaOe", sdaOe, 1'b0);
    rstN = 1'b1; enable = 1'b1;
    @(negedge clk);

    // Table walk: R2 compare, R4/R5 direction, R8 driver timing
    foreach (VEC[v]) begin
      logic m;
      logic [6:0] la;
      logic [7:0] fr;
      m = VEC[v][15]; la = VEC[v][14:8]; fr = VEC[v][7:0];
      isMaster = m; localAddr = la;
      pulseStart();
      chk("R3 start clears addrMatch", addrMatch, 1'b0);
      chk("R6 start clears txFlag", txFlag, 1'b0);
      sendFirst(fr, m);
      chk("R2 addrMatch", addrMatch, fr[7:1] == la);
      chk(m ? "R5 txFlag" : "R4 txFlag", txFlag, fr[0]);
      chk("R8 sdaOe before ninth", sdaOe, 1'b0);
      sdaIn = 1'b0; sclRise = 1'b1; @(negedge clk); sclRise = 1'b0;
      chk("R8 sdaOe after ninth rise", sdaOe, 1'b0);
      sclFall = 1'b1; @(negedge clk); sclFall = 1'b0;
      chk("R8 sdaOe after ninth fall", sdaOe, fr[0]);
    end

    // R9: a later byte does not change the flags (last vector matched, tx=1)
    for (int i = 0; i < 9; i++) sendBit(i[0]);
    chk("R9 addrMatch held", addrMatch, 1'b1);
    chk("R9 txFlag held", txFlag, 1'b1);

    // R3/R6: stop clears both
    pulseStop();
    chk("R3 stop addrMatch", addrMatch, 1'b0);
    chk("R6 stop txFlag", txFlag, 1'b0);
    chk("R6 stop sdaOe", sdaOe, 1'b0);

    // Slave, local 0x35, read request
    isMaster = 1'b0; localAddr = 7'h35;

    // R6: arbitration loss clears txFlag but not addrMatch
    pulseStart(); sendFirst({7'h35, 1'b1}, 1'b0);
    arbLost = 1'b1; @(negedge clk); arbLost = 1'b0; @(negedge clk);
    chk("R6 arbLost txFlag", txFlag, 1'b0);
    chk("R6 arbLost keeps addrMatch", addrMatch, 1'b1);

    // R3/R6: release strobe
    pulseStart(); sendFirst({7'h35, 1'b1}, 1'b0);
    relStrobe = 1'b1; @(negedge clk); relStrobe = 1'b0; @(negedge clk);
    chk("R3 release addrMatch", addrMatch, 1'b0);
    chk("R6 release txFlag", txFlag, 1'b0);

    // R3/R6: enable falling
    pulseStart(); sendFirst({7'h35, 1'b1}, 1'b0);
    sendBit(1'b0);
    chk("R8 sdaOe on before disable", sdaOe, 1'b1);
    enable = 1'b0; @(negedge clk); @(negedge clk);
    chk("R3 disable addrMatch", addrMatch, 1'b0);
    chk("R6 disable txFlag", txFlag, 1'b0);
    chk("R6 disable sdaOe", sdaOe, 1'b0);

    // R11: bus activity while disabled
    pulseStart(); sendFirst({7'h35, 1'b1}, 1'b0);
    chk("R11 addrMatch disabled", addrMatch, 1'b0);
    chk("R11 txFlag disabled", txFlag, 1'b0);
    enable = 1'b1; @(negedge clk);

    // R7: wait cancel before and after the ninth rise
    pulseStart(); sendFirst({7'h35, 1'b1}, 1'b0);
    waitCancel = 1'b1; @(negedge clk); waitCancel = 1'b0; @(negedge clk);
    chk("R7 early waitCancel ignored", txFlag, 1'b1);
    sendBit(1'b0);
    chk("R7 sdaOe on before cancel", sdaOe, 1'b1);
    waitCancel = 1'b1; @(negedge clk); waitCancel = 1'b0; @(negedge clk);
    chk("R7 waitCancel txFlag", txFlag, 1'b0);
    chk("R7 waitCancel sdaOe", sdaOe, 1'b0);
    chk("R7 waitCancel keeps addrMatch", addrMatch, 1'b1);

    // R10: release in the same cycle as the eighth rise
    pulseStart();
    for (int i = 7; i >= 1; i--) sendBit(((7'h35 >> (i - 1)) & 7'h01) != 0);
    sdaIn = 1'b1; sclRise = 1'b1; relStrobe = 1'b1; @(negedge clk);
    sclRise = 1'b0; relStrobe = 1'b0; @(negedge clk);
    chk("R10 addrMatch clear wins", addrMatch, 1'b0);
    chk("R10 txFlag clear wins", txFlag, 1'b0);

    // R10: stop in the same cycle as the eighth rise
    pulseStart();
    for (int i = 7; i >= 1; i--) sendBit(((7'h35 >> (i - 1)) & 7'h01) != 0);
    sdaIn = 1'b1; sclRise = 1'b1; stopDet = 1'b1; @(negedge clk);
    sclRise = 1'b0; stopDet = 1'b0; @(negedge clk);
    chk("R10 stop addrMatch", addrMatch, 1'b0);
    chk("R10 stop txFlag", txFlag, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule